// File: doc/BRIEF.md
# Supply Monitor Event Controller

This block is the digital decision logic of a supply-voltage supervisor. Two comparator outputs reach it from the analog side. One reports that the supply is at or below a programmable low-voltage level. The other reports that the supply is at or below a fixed brown-out level. Each comparator output passes through a synchroniser and a glitch filter. The filtered result then sets a sticky status flag. Depending on the configuration, it also raises a level interrupt or a power-down reset request that comes together with a regulator shutdown request.

Software reaches the block through a single control/status word with a write strobe and a read-back bus. The word holds:
- the enables,
- the 3-bit threshold select, which goes out to the analog reference,
- the brown-out response mode,
- the two write-one-to-clear flags.

In reset mode, a brown-out latches the reset and regulator-off requests until the external power-on reset clears the block. In interrupt mode, the brown-out only interrupts the CPU, so that firmware can run its own shutdown sequence.

Top module: `supply_event_ctrl`

## Requirements
- R1: After `rst_n` is low, `rd_data` reads 0 and `irq_o`, `por_req_o`, `ldo_off_o` and `lvd_sel_o` are all 0.
- R2: A write with `wr_en` high stores `wr_data[6:0]` into the control fields. The field positions are: bit 0 low-voltage detector enable, bit 1 low-voltage interrupt enable, bits 4:2 threshold select, bit 5 brown-out enable, bit 6 brown-out mode (0 reset, 1 interrupt). Bit 7 reads 0. `lvd_sel_o` equals bits 4:2.
- R3: A comparator input only counts after it has held a new level for `FILT_LEN` (default 4) consecutive clock edges past the 2-flop synchroniser. With defaults, a high pulse spanning 3 edges sets no flag, and one spanning 4 edges does.
- R4: The low-voltage flag (read bit 8) sets only when the filtered low-voltage comparator is high and the detector enable is 1.
- R5: The low-voltage flag drives `irq_o` only when both the detector enable and the low-voltage interrupt enable are 1.
- R6: The brown-out flag (read bit 9) sets only when the filtered brown-out comparator is high and the brown-out enable is 1.
- R7: In brown-out mode 0, a detected brown-out raises `por_req_o` and `ldo_off_o` in the same cycle. Both stay high until `rst_n` goes low. The brown-out does not drive `irq_o`.
- R8: In brown-out mode 1, a detected brown-out sets the brown-out flag and drives `irq_o`. `por_req_o` stays 0.
- R9: Writing 1 to bit 8 or bit 9 clears that flag, but only while its filtered comparator is low. While the condition is still present, the clear is ignored. Writing 0 to a flag bit leaves it unchanged.
- R10: `irq_o` is a level that falls once the flags behind it are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low external power-on reset, asynchronous assert |
| lvd_cmp_i | input | 1 | Asynchronous low-voltage comparator output, high = supply at/below selected level |
| bod_cmp_i | input | 1 | Asynchronous brown-out comparator output, high = supply at/below brown-out level |
| wr_en | input | 1 | Write strobe for the control/status word |
| wr_data | input | 10 | Write data: control fields in bits 6:0, write-one-to-clear flags in bits 9:8 |
| rd_data | output | 10 | Current control fields and flags |
| lvd_sel_o | output | 3 | Threshold select to the analog reference |
| irq_o | output | 1 | Level interrupt request |
| por_req_o | output | 1 | Power-down reset request |
| ldo_off_o | output | 1 | Internal regulator disable request |

## Verification
The hardest case to reach is a flag-clear write that arrives while the filtered comparator is still high. To prove the clear is ignored, the write must land after the flag has set but before the filter has seen the input fall. The bench therefore holds the comparator high across the write and clears only after waiting well beyond the filter length. It also exercises the exact filter boundary with pulses spanning one edge fewer than, and exactly, the filter length. It confirms that the sticky reset request survives both the brown-out disappearing and a change of mode, until `rst_n` is pulsed.

// File: rtl/supply_mon_pkg.sv
`timescale 1ns/1ps
package supply_mon_pkg;
   localparam int REG_W      = 10;
   localparam int SEL_W      = 3;
   localparam int BIT_LVD_EN = 0;
   localparam int BIT_LVD_IE = 1;
   localparam int SEL_LSB    = 2;
   localparam int BIT_BOD_EN = 5;
   localparam int BIT_BOD_MD = 6;
   localparam int BIT_LVD_FL = 8;
   localparam int BIT_BOD_FL = 9;
   localparam int NUM_CH     = 2;

   typedef enum logic [0:0] {
      CH_LVD = 1'b0,
      CH_BOD = 1'b1
   } mon_ch_e;

   typedef struct packed {
      logic             bod_mode;
      logic             bod_en;
      logic [SEL_W-1:0] lvd_sel;
      logic             lvd_ie;
      logic             lvd_en;
   } mon_cfg_t;
endpackage

// File: rtl/supply_sync_filter.sv
`timescale 1ns/1ps
module supply_sync_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic filt_o
);
   localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], async_i};
   end

   if (FILT_LEN <= 1) begin : g_nofilt
      logic lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q <= 1'b0;
         else        lvl_q <= sync_q[SYNC_STAGES-1];
      end
      assign filt_o = lvl_q;
   end else begin : g_filt
      logic          lvl_q;
      logic [CW-1:0] run_q;
      logic          diff;
      assign diff = sync_q[SYNC_STAGES-1] ^ lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q <= 1'b0;
            run_q <= '0;
         end else if (!diff) begin
            run_q <= '0;
         end else if (run_q == CW'(FILT_LEN - 1)) begin
            lvl_q <= sync_q[SYNC_STAGES-1];
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
      assign filt_o = lvl_q;
   end
endmodule

// File: rtl/supply_sticky_flag.sv
`timescale 1ns/1ps
module supply_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic hold_i,
   output logic flag_o
);
   logic flag_q;
   logic clr_ok;

   assign clr_ok = clr_i & ~hold_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= set_i | (flag_q & ~clr_ok);
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/supply_event_ctrl.sv
`timescale 1ns/1ps
module supply_event_ctrl
   import supply_mon_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvd_cmp_i,
   input  logic             bod_cmp_i,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic [SEL_W-1:0] lvd_sel_o,
   output logic             irq_o,
   output logic             por_req_o,
   output logic             ldo_off_o
);
   localparam int CFG_W = $bits(mon_cfg_t);

   mon_cfg_t          cfg_q;
   logic [NUM_CH-1:0] cmp_raw;
   logic [NUM_CH-1:0] cmp_filt;
   logic [NUM_CH-1:0] ch_en;
   logic [NUM_CH-1:0] ch_set;
   logic [NUM_CH-1:0] ch_clr;
   logic [NUM_CH-1:0] ch_flag;
   logic              bod_trip;
   logic              por_q;
   logic              ldo_q;

   assign cmp_raw[CH_LVD] = lvd_cmp_i;
   assign cmp_raw[CH_BOD] = bod_cmp_i;
   assign ch_en[CH_LVD]   = cfg_q.lvd_en;
   assign ch_en[CH_BOD]   = cfg_q.bod_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q <= '0;
      else if (wr_en) cfg_q <= mon_cfg_t'(wr_data[CFG_W-1:0]);
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      supply_sync_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .FILT_LEN    (FILT_LEN)
      ) u_filt (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (cmp_raw[c]),
         .filt_o  (cmp_filt[c])
      );

      assign ch_set[c] = cmp_filt[c] & ch_en[c];
      assign ch_clr[c] = wr_en & wr_data[BIT_LVD_FL + c];

      supply_sticky_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (ch_set[c]),
         .clr_i  (ch_clr[c]),
         .hold_i (cmp_filt[c]),
         .flag_o (ch_flag[c])
      );
   end

   assign bod_trip = ch_set[CH_BOD] & ~cfg_q.bod_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         por_q <= 1'b0;
         ldo_q <= 1'b0;
      end else begin
         por_q <= por_q | bod_trip;
         ldo_q <= ldo_q | bod_trip;
      end
   end

   assign irq_o = (ch_flag[CH_LVD] & cfg_q.lvd_en & cfg_q.lvd_ie)
                | (ch_flag[CH_BOD] & cfg_q.bod_en & cfg_q.bod_mode);

   assign por_req_o = por_q;
   assign ldo_off_o = ldo_q;
   assign lvd_sel_o = cfg_q.lvd_sel;
   assign rd_data   = {ch_flag[CH_BOD], ch_flag[CH_LVD], 1'b0, cfg_q};
endmodule

// File: rtl/supply_event_ctrl_chk.sv
`timescale 1ns/1ps
module supply_event_ctrl_chk
   import supply_mon_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] rd_data,
   input logic             irq_o,
   input logic             por_req_o,
   input logic             ldo_off_o
);
   p_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      por_req_o == ldo_off_o);

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      por_req_o |=> por_req_o);

   p_reset_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(por_req_o) |-> $past(rd_data[BIT_BOD_EN] && !rd_data[BIT_BOD_MD]));

   p_lvd_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[BIT_LVD_FL]) |-> $past(rd_data[BIT_LVD_EN]));

   p_bod_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[BIT_BOD_FL]) |-> $past(rd_data[BIT_BOD_EN]));

   p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((rd_data[BIT_LVD_EN] && rd_data[BIT_LVD_IE])
              || (rd_data[BIT_BOD_EN] && rd_data[BIT_BOD_MD])));

   p_lvd_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[BIT_LVD_FL] && !(wr_en && wr_data[BIT_LVD_FL])) |=> rd_data[BIT_LVD_FL]);

   p_bod_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[BIT_BOD_FL] && !(wr_en && wr_data[BIT_BOD_FL])) |=> rd_data[BIT_BOD_FL]);
endmodule

bind supply_event_ctrl supply_event_ctrl_chk u_chk (.*);

// File: tb/supply_event_ctrl_tb.sv
`timescale 1ns/1ps
module supply_event_ctrl_tb;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         lvd_cmp_i = 1'b0;
   logic         bod_cmp_i = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic [2:0]   lvd_sel_o;
   logic         irq_o;
   logic         por_req_o;
   logic         ldo_off_o;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 1'b0;

   always #2.5 clk = ~clk;

   supply_event_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .lvd_cmp_i(lvd_cmp_i), .bod_cmp_i(bod_cmp_i),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .lvd_sel_o(lvd_sel_o),
      .irq_o(irq_o), .por_req_o(por_req_o), .ldo_off_o(ldo_off_o)
   );

   // control word values: bit0 lvd_en, bit1 lvd_ie, 4:2 sel, bit5 bod_en, bit6 mode
   localparam logic [W-1:0] CFG_VEC [8] = '{
      10'h001, 10'h002, 10'h01C, 10'h014, 10'h020, 10'h040, 10'h07F, 10'h0FF
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_word(input logic [W-1:0] v);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_lvd(input int edges);
      @(negedge clk);
      lvd_cmp_i = 1'b1;
      repeat (edges) @(negedge clk);
      lvd_cmp_i = 1'b0;
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   initial begin
      idle(3);
      // R1: reset state
      check("R1 rd_data", 32'(rd_data), 0);
      check("R1 irq", 32'(irq_o), 0);
      check("R1 por/ldo", 32'({por_req_o, ldo_off_o}), 0);
      rst_n = 1'b1;
      idle(2);
      check("R1 sel", 32'(lvd_sel_o), 0);

      // R2: table walk of control writes
      for (int i = 0; i < 8; i++) begin
         write_word(CFG_VEC[i]);
         check("R2 readback", 32'(rd_data), 32'(CFG_VEC[i] & 10'h07F));
         check("R2 sel out", 32'(lvd_sel_o), 32'(CFG_VEC[i][4:2]));
      end
      write_word(10'h000);

      // R4: detector disabled -> no flag
      pulse_lvd(8);
      idle(10);
      check("R4 no flag when disabled", 32'(rd_data[8]), 0);

      // R3: filter boundary
      write_word(10'h001);
      pulse_lvd(3);
      idle(10);
      check("R3 3-edge glitch rejected", 32'(rd_data[8]), 0);
      pulse_lvd(4);
      idle(10);
      check("R3 4-edge pulse sets flag", 32'(rd_data[8]), 1);
      check("R5 no irq without ie", 32'(irq_o), 0);

      // R5: enable interrupt
      write_word(10'h003);
      check("R5 irq with en+ie", 32'(irq_o), 1);

      // R9/R10: clear while condition present is ignored
      @(negedge clk);
      lvd_cmp_i = 1'b1;
      idle(12);
      write_word(10'h103);
      check("R9 clear ignored while present", 32'(rd_data[8]), 1);
      lvd_cmp_i = 1'b0;
      idle(12);
      write_word(10'h003);
      check("R9 write 0 keeps flag", 32'(rd_data[8]), 1);
      write_word(10'h103);
      check("R9 clear after condition gone", 32'(rd_data[8]), 0);
      check("R10 irq drops", 32'(irq_o), 0);

      // R6: brown-out disabled
      write_word(10'h000);
      @(negedge clk);
      bod_cmp_i = 1'b1;
      idle(12);
      check("R6 no bod flag when disabled", 32'(rd_data[9]), 0);
      check("R7 no reset when disabled", 32'(por_req_o), 0);
      bod_cmp_i = 1'b0;
      idle(12);

      // R7: mode 0 reset response
      write_word(10'h020);
      @(negedge clk);
      bod_cmp_i = 1'b1;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (por_req_o !== ldo_off_o)
            check("R7 reset/ldo same cycle", 32'(ldo_off_o), 32'(por_req_o));
      end
      check("R7 por asserted", 32'(por_req_o), 1);
      check("R7 ldo off asserted", 32'(ldo_off_o), 1);
      check("R6 bod flag set", 32'(rd_data[9]), 1);
      check("R7 no irq in reset mode", 32'(irq_o), 0);
      bod_cmp_i = 1'b0;
      idle(12);
      write_word(10'h260);
      check("R7 requests sticky", 32'({por_req_o, ldo_off_o}), 3);
      do_reset();
      check("R7 cleared by rst_n", 32'({por_req_o, ldo_off_o}), 0);
      check("R1 flags cleared by rst_n", 32'(rd_data), 0);

      // R8: mode 1 interrupt response
      write_word(10'h060);
      @(negedge clk);
      bod_cmp_i = 1'b1;
      idle(12);
      check("R8 bod flag", 32'(rd_data[9]), 1);
      check("R8 irq raised", 32'(irq_o), 1);
      check("R8 no reset", 32'({por_req_o, ldo_off_o}), 0);
      bod_cmp_i = 1'b0;
      idle(12);
      write_word(10'h260);
      check("R9 bod flag cleared", 32'(rd_data[9]), 0);
      check("R10 irq low after clear", 32'(irq_o), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule